// File: doc/BRIEF.md
# Host Port Byte-Serial Memory Target

This block sits on the DSP side of a host port and gives an external host access to a small internal word memory. The host selects one of three registers with a 2-bit select code: a control register, an address register or a data register. Every access to the data register reads or writes the memory word that the address register points at. Two data codes exist. One steps the address automatically and the other leaves it where it is. This allows block transfers and repeated single-word polling without reloading the address.

In the default narrow build the host bus is 8 bits wide, and each 16-bit word moves as two byte cycles. A byte-identification input tells the first byte from the second. A byte-order bit in the control register decides which half of the word the first byte carries. Write bytes are collected in a holding register, and the memory write happens only on the second byte. On reads, the whole word is fetched on the first byte and the second byte comes from a latch. In the wide build, set by a parameter, every cycle carries a full word and the byte-identification input is ignored.

Top module: `hpi_target`

## Requirements
- R1: After reset the address register is 0, the byte-order bit is 1 (first byte is the upper half) and `hp_rvalid` is low.
- R2: Select codes: 2'b00 is the control register, with the byte-order bit at bit 0 and zeros above it. 2'b10 is the address register, which reads back zero-extended. 2'b01 is data with address stepping. 2'b11 is data with no address change.
- R3: Narrow build: with the byte-order bit at 1, the first byte (`hp_byte_id`=0) is bits 15:8 and the second byte (`hp_byte_id`=1) is bits 7:0. With the bit at 0, the halves swap. This applies to both reads and writes.
- R4: Narrow build, code 2'b01 write: the address steps before the write, so the word lands at A+1 and the address register ends at A+1.
- R5: Narrow build, code 2'b01 read: the word at A is returned, and the address register becomes A+1 once the second byte is served.
- R6: Code 2'b11 reads and writes the word at A and leaves the address register unchanged.
- R7: Narrow build: a write commits only when a second byte follows a first byte. A second byte with no first byte staged is ignored. A lone first byte changes no memory word.
- R8: Each read byte cycle puts its data on `hp_rdata` with `hp_rvalid` high in the cycle after the strobe. `hp_rvalid` is low after any cycle without a read strobe.
- R9: No register or memory word changes in a cycle unless both `hp_cs` and `hp_stb` are high.
- R10: The address register wraps from 2^ADDR_W-1 to 0 when it steps, on both reads and writes.
- R11: Wide build: each strobe moves a full 16-bit word, and `hp_byte_id` is ignored. Code 2'b01 steps the address after the access for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_cs | input | 1 | Chip select, high to qualify a cycle |
| hp_stb | input | 1 | Byte/word strobe, one cycle per transfer |
| hp_rnw | input | 1 | 1 = read, 0 = write |
| hp_sel | input | 2 | Register select code |
| hp_byte_id | input | 1 | 0 = first byte, 1 = second byte (narrow build) |
| hp_wdata | input | BUS_W | Write data (8 narrow, 16 wide) |
| hp_rdata | output | BUS_W | Read data, registered |
| hp_rvalid | output | 1 | High the cycle after a read strobe |

## Verification
On every cycle, the assertions check several things: the address register holds still without a qualified strobe, a step adds exactly one and wraps at the top, the staging flag follows first and second bytes, and `hp_rvalid` follows each read strobe by one cycle. Other behaviour shows only in the bench scenarios, by writing through one path and reading back through another. These cover the pre-step landing address of stepped writes, the post-step of stepped reads, the halves placed by each byte-order setting, the rejection of orphan second bytes and the full-word behaviour of the wide build.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA_FIX = 2'b11
  } hpi_sel_e;

  function automatic logic is_data(hpi_sel_e s);
    return (s == SEL_DATA_INC) || (s == SEL_DATA_FIX);
  endfunction

  // Build a word from two bytes in arrival order.
  function automatic logic [WORD_W-1:0] join_bytes(logic [BYTE_W-1:0] first_b,
                                                   logic [BYTE_W-1:0] second_b,
                                                   logic first_hi);
    return first_hi ? {first_b, second_b} : {second_b, first_b};
  endfunction

  // Choose the half of a word that a given byte slot carries.
  function automatic logic [BYTE_W-1:0] pick_byte(logic [WORD_W-1:0] w,
                                                  logic first_hi,
                                                  logic is_second);
    return (first_hi ^ is_second) ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/hpi_regs.sv
module hpi_regs #(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              ctl_wr,
  input  logic              ctl_bit,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              addr_step,
  output logic [ADDR_W-1:0] hpa,
  output logic              bob
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpa <= '0;
      bob <= 1'b1;
    end else begin
      if (addr_wr)        hpa <= addr_in;
      else if (addr_step) hpa <= hpa + ADDR_W'(1);
      if (ctl_wr)         bob <= ctl_bit;
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(hpa) && $stable(bob)));

  // R4 R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && !addr_wr) |=> (hpa == $past(hpa) + ADDR_W'(1)));

  // R10
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && !addr_wr && (hpa == '1)) |=> (hpa == '0));
endmodule

// File: rtl/hpi_stage.sv
module hpi_stage import hpi_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_seen,
  input  logic              first_wr,
  input  logic              second_seen,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] stage_byte,
  output logic              pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_byte <= '0;
      pending    <= 1'b0;
    end else begin
      if (first_wr)         stage_byte <= byte_in;
      if (first_seen)       pending <= 1'b1;
      else if (second_seen) pending <= 1'b0;
    end
  end

  // R7
  stage_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_seen |=> pending);

  // R7
  stage_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (second_seen && !first_seen) |=> !pending);
endmodule

// File: rtl/hpi_ram.sv
module hpi_ram import hpi_pkg::*; #(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hpi_target.sv
module hpi_target import hpi_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter bit WIDE   = 1'b0,
  localparam int BUS_W = WIDE ? WORD_W : BYTE_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hp_cs,
  input  logic             hp_stb,
  input  logic             hp_rnw,
  input  logic [1:0]       hp_sel,
  input  logic             hp_byte_id,
  input  logic [BUS_W-1:0] hp_wdata,
  output logic [BUS_W-1:0] hp_rdata,
  output logic             hp_rvalid
);
  hpi_sel_e          sel;
  logic              acc, done_ev, wr_done, fetch_ev, serve2_ev, step_ev;
  logic              first_ev, second_ev, pending;
  logic [BYTE_W-1:0] stage_byte;
  logic [WORD_W-1:0] wr_word, mem_rdata, src_word;
  logic [ADDR_W-1:0] hpa, mem_waddr;
  logic              bob, mem_we, ctl_wr, addr_wr;
  logic [BUS_W-1:0]  rd_q;
  logic              rv_q;

  assign sel = hpi_sel_e'(hp_sel);
  assign acc = hp_cs && hp_stb;

  generate
    if (WIDE) begin : g_wide
      assign first_ev   = 1'b0;
      assign second_ev  = 1'b0;
      assign pending    = 1'b0;
      assign stage_byte = '0;
      assign done_ev    = acc;
      assign fetch_ev   = acc && hp_rnw;
      assign serve2_ev  = 1'b0;
      assign wr_word    = hp_wdata;
      assign mem_waddr  = hpa;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_q <= '0;
        else if (fetch_ev) rd_q <= src_word;
      end
    end else begin : g_narrow
      logic [WORD_W-1:0] rd_latch;

      assign first_ev  = acc && !hp_byte_id;
      assign second_ev = acc && hp_byte_id;
      assign done_ev   = second_ev && pending;
      assign fetch_ev  = first_ev && hp_rnw;
      assign serve2_ev = second_ev && hp_rnw;
      assign wr_word   = join_bytes(stage_byte, hp_wdata, bob);
      // Stepped writes move the address first, then store there.
      assign mem_waddr = (sel == SEL_DATA_INC) ? hpa + ADDR_W'(1) : hpa;

      hpi_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_seen (first_ev),
        .first_wr   (first_ev && !hp_rnw),
        .second_seen(second_ev),
        .byte_in    (hp_wdata),
        .stage_byte (stage_byte),
        .pending    (pending)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q     <= '0;
          rd_latch <= '0;
        end else if (fetch_ev) begin
          rd_q     <= pick_byte(src_word, bob, 1'b0);
          rd_latch <= src_word;
        end else if (serve2_ev) begin
          rd_q     <= pick_byte(rd_latch, bob, 1'b1);
        end
      end
    end
  endgenerate

  assign wr_done = done_ev && !hp_rnw;
  assign step_ev = done_ev && (sel == SEL_DATA_INC);
  assign mem_we  = wr_done && is_data(sel);
  assign ctl_wr  = wr_done && (sel == SEL_CTRL);
  assign addr_wr = wr_done && (sel == SEL_ADDR);

  always_comb begin
    case (sel)
      SEL_CTRL: src_word = {{(WORD_W-1){1'b0}}, bob};
      SEL_ADDR: src_word = WORD_W'(hpa);
      default:  src_word = mem_rdata;
    endcase
  end

  hpi_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .ctl_wr   (ctl_wr),
    .ctl_bit  (wr_word[0]),
    .addr_wr  (addr_wr),
    .addr_in  (wr_word[ADDR_W-1:0]),
    .addr_step(step_ev),
    .hpa      (hpa),
    .bob      (bob)
  );

  hpi_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(wr_word),
    .raddr(hpa),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= fetch_ev || serve2_ev;
  end

  assign hp_rdata  = rd_q;
  assign hp_rvalid = rv_q;

  // R8
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hp_rnw) |=> hp_rvalid);

  // R8
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && hp_rnw) |=> !hp_rvalid);

  // R9
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (hp_cs && hp_stb && !hp_rnw));
endmodule

// File: tb/hpi_target_tb.sv
`timescale 1ns/1ps
module hpi_target_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, stb = 1'b0, rnw = 1'b0, bid = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [7:0]  wd8 = '0;
  logic [7:0]  rd8;
  logic        rv8;
  logic        w_cs = 1'b0, w_stb = 1'b0;
  logic [15:0] wd16 = '0;
  logic [15:0] rd16;
  logic        rv16;
  logic        m_bob = 1'b1;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  hpi_target u_dut (
    .clk(clk), .rst_n(rst_n), .hp_cs(cs), .hp_stb(stb), .hp_rnw(rnw),
    .hp_sel(sel), .hp_byte_id(bid), .hp_wdata(wd8),
    .hp_rdata(rd8), .hp_rvalid(rv8));

  hpi_target #(.WIDE(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .hp_cs(w_cs), .hp_stb(w_stb), .hp_rnw(rnw),
    .hp_sel(sel), .hp_byte_id(bid), .hp_wdata(wd16),
    .hp_rdata(rd16), .hp_rvalid(rv16));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One narrow byte cycle; read data sampled the cycle after the strobe.
  task automatic cyc8(input logic c, input logic s, input logic r, input logic [1:0] sl,
                      input logic b, input logic [7:0] d, output logic [7:0] q, output logic v);
    @(negedge clk);
    cs = c; stb = s; rnw = r; sel = sl; bid = b; wd8 = d;
    @(negedge clk);
    q = rd8; v = rv8;
    cs = 1'b0; stb = 1'b0;
  endtask

  task automatic wr8(input logic [1:0] sl, input logic [15:0] w);
    logic [7:0] q; logic v;
    cyc8(1, 1, 0, sl, 0, m_bob ? w[15:8] : w[7:0], q, v);
    cyc8(1, 1, 0, sl, 1, m_bob ? w[7:0] : w[15:8], q, v);
  endtask

  task automatic rd8w(input logic [1:0] sl, output logic [15:0] w);
    logic [7:0] q0, q1; logic v0, v1;
    cyc8(1, 1, 1, sl, 0, 8'h00, q0, v0);
    check("R8 first byte valid", v0, 1);
    cyc8(1, 1, 1, sl, 1, 8'h00, q1, v1);
    check("R8 second byte valid", v1, 1);
    w = m_bob ? {q0, q1} : {q1, q0};
  endtask

  task automatic cycw(input logic [1:0] sl, input logic r, input logic [15:0] d,
                      output logic [15:0] q, output logic v);
    @(negedge clk);
    w_cs = 1'b1; w_stb = 1'b1; rnw = r; sel = sl; bid = 1'b1; wd16 = d;
    @(negedge clk);
    q = rd16; v = rv16;
    w_cs = 1'b0; w_stb = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R1 rvalid low", rv8, 0);
    rd8w(2'b00, w);
    check("R1 R2 control reads byte-order 1", w, 16'h0001);
    rd8w(2'b10, w);
    check("R1 R2 address is 0", w, 0);
  endtask

  task automatic t_fixed();
    logic [15:0] w;
    wr8(2'b10, 16'h0005);
    wr8(2'b11, 16'hA5C3);
    rd8w(2'b11, w);
    check("R6 fixed data readback", w, 16'hA5C3);
    rd8w(2'b10, w);
    check("R6 address unchanged", w, 5);
  endtask

  task automatic t_step_write();
    logic [15:0] w;
    wr8(2'b01, 16'h1111);
    rd8w(2'b10, w);
    check("R4 address stepped", w, 6);
    rd8w(2'b11, w);
    check("R4 word landed at A+1", w, 16'h1111);
    wr8(2'b10, 16'h0005);
    rd8w(2'b11, w);
    check("R4 word at A untouched", w, 16'hA5C3);
  endtask

  task automatic t_step_read();
    logic [15:0] w;
    wr8(2'b10, 16'h0006);
    rd8w(2'b01, w);
    check("R5 stepped read returns word at A", w, 16'h1111);
    rd8w(2'b10, w);
    check("R5 address now A+1", w, 7);
  endtask

  task automatic t_order();
    logic [7:0] q; logic v; logic [15:0] w;
    wr8(2'b00, 16'h0000);
    m_bob = 1'b0;
    cyc8(1, 1, 0, 2'b11, 0, 8'h34, q, v);
    cyc8(1, 1, 0, 2'b11, 1, 8'h12, q, v);
    cyc8(1, 1, 1, 2'b11, 0, 8'h00, q, v);
    check("R3 order 0 first byte is low half", q, 8'h34);
    cyc8(1, 1, 1, 2'b11, 1, 8'h00, q, v);
    check("R3 order 0 second byte is high half", q, 8'h12);
    wr8(2'b00, 16'h0001);
    m_bob = 1'b1;
    cyc8(1, 1, 1, 2'b11, 0, 8'h00, q, v);
    check("R3 order 1 first byte is high half", q, 8'h12);
    rd8w(2'b00, w);
    check("R2 control bit back to 1", w, 16'h0001);
  endtask

  task automatic t_orphan();
    logic [7:0] q; logic v; logic [15:0] w;
    cyc8(1, 1, 0, 2'b11, 1, 8'hFF, q, v);
    rd8w(2'b11, w);
    check("R7 orphan second byte ignored", w, 16'h1234);
    cyc8(1, 1, 0, 2'b11, 0, 8'h99, q, v);
    rd8w(2'b11, w);
    check("R7 lone first byte not committed", w, 16'h1234);
  endtask

  task automatic t_idle();
    logic [7:0] q; logic v; logic [15:0] w;
    cyc8(0, 1, 0, 2'b10, 0, 8'h00, q, v);
    cyc8(0, 1, 0, 2'b10, 1, 8'h2A, q, v);
    cyc8(1, 0, 0, 2'b10, 0, 8'h00, q, v);
    cyc8(1, 0, 0, 2'b10, 1, 8'h2A, q, v);
    cyc8(0, 1, 1, 2'b11, 0, 8'h00, q, v);
    check("R8 R9 no rvalid without select", v, 0);
    rd8w(2'b10, w);
    check("R9 address unchanged while idle", w, 7);
  endtask

  task automatic t_wrap();
    logic [15:0] w;
    wr8(2'b10, 16'h003F);
    wr8(2'b01, 16'hC0DE);
    rd8w(2'b10, w);
    check("R10 write step wraps to 0", w, 0);
    rd8w(2'b11, w);
    check("R10 word stored at 0", w, 16'hC0DE);
    wr8(2'b10, 16'h003F);
    wr8(2'b11, 16'h7E7E);
    rd8w(2'b01, w);
    check("R10 read at top", w, 16'h7E7E);
    rd8w(2'b10, w);
    check("R10 read step wraps to 0", w, 0);
  endtask

  task automatic t_wide();
    logic [15:0] q; logic v;
    cycw(2'b10, 0, 16'h0003, q, v);
    cycw(2'b01, 0, 16'hBEEF, q, v);
    cycw(2'b10, 1, 16'h0, q, v);
    check("R11 wide write post-step", q, 4);
    check("R11 R8 wide rvalid", v, 1);
    cycw(2'b10, 0, 16'h0003, q, v);
    cycw(2'b01, 1, 16'h0, q, v);
    check("R11 wide read word", q, 16'hBEEF);
    cycw(2'b10, 1, 16'h0, q, v);
    check("R11 wide read post-step", q, 4);
    cycw(2'b11, 0, 16'h0102, q, v);
    cycw(2'b11, 1, 16'h0, q, v);
    check("R11 wide fixed data", q, 16'h0102);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_step_write();
    t_step_read();
    t_order();
    t_orphan();
    t_idle();
    t_wrap();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule